// File: doc/BRIEF.md
# Spread-Pulse Quasi-Analog Output

This block turns an 8-bit level into a pin waveform whose average duty tracks that level. A modulation period is split into 256 slots of four clocks each. In each period exactly as many slots are driven high as the level value says. Those high slots are scattered across the period as evenly as integer arithmetic allows. A conventional PWM would instead produce one long high stretch. Because the energy is spread out, a simple external RC network settles to a smoother voltage, and the ripple is at a much higher frequency than with one pulse per period.

Several channels share one slot timebase. Each channel has its own level register, output-enable bit and invert bit. A level is written through a shared data bus with a per-channel write strobe. The register cannot be read back. A newly written level is held in a staging copy and only takes over at the next period boundary, so no period ever mixes two levels. When a channel is disabled, its drive output is forced low and its pin-enable output is low, so the pad can float or be used for something else.

The default configuration has two channels that behave identically. Reset is asynchronous and active low, and it must be released in step with the clock.

Top module: `spread_pulse_dac`

## Requirements
- R1: With output enable 1 and invert 0, a channel whose active level is N drives pin_drive high for exactly 4*N clock cycles in every 1024-cycle period.
- R2: pin_drive changes only at slot boundaries, which fall every 4 clocks counted from reset release. The exceptions are a change of that channel's out_en or invert. Every high stretch is therefore a whole number of 4-clock slots.
- R3: Slot s (0..255) of a period is high exactly when floor((s+1)*N/256) > floor(s*N/256). For N up to 128, no two neighbouring slots in a period are both high.
- R4: A level of 0 keeps the un-inverted waveform low for the whole period. A level of 255 leaves exactly one low slot in each period, which is slot 0.
- R5: With out_en bit 0 for a channel, the next clock drives that channel's pin_drive and pin_oe low, whatever the invert bit is. With out_en 1, pin_oe is 1 on the next clock.
- R6: With out_en 1 and invert 1, pin_drive is the complement of the R3 waveform, giving 1024-4*N high cycles per period.
- R7: A level written during a period takes effect only at the start of the next period. The last write before the boundary wins. The level register has no read path.
- R8: A write loads only the channels whose bit in wr_en is 1. Bit i of wr_en selects channel i.
- R9: During reset, pin_drive and pin_oe are 0. All levels reset to 0. Slot 0 of the first period starts on the first clock after reset release, and pin_drive reflects each slot one clock after it starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | NCH (2) | Per-channel level write strobe |
| wr_data | input | DW (8) | Level value written to the selected channels |
| out_en | input | NCH (2) | Per-channel output enable |
| invert | input | NCH (2) | Per-channel waveform inversion |
| pin_drive | output | NCH (2) | Per-channel pin data drive |
| pin_oe | output | NCH (2) | Per-channel pin output enable |

## Verification
A wrong accumulator or active level changes which slots are high. It shows up within one 4-clock slot as a pin value that differs from the floor-formula pattern. By the end of the period it also shows up as a wrong high-cycle total. A wrong prescaler or slot counter shifts the slot boundaries, and the first edge falls off the 4-clock grid. A level that loads early or reaches the wrong channel changes the pattern inside the very period where the write happened. All of these are compared cycle by cycle against a model, and each period's totals are checked.

// File: rtl/spd_pkg.sv
package spd_pkg;
  // Strobes issued by the shared slot timebase.
  typedef struct packed {
    logic slot_tick;   // last clock of a slot
    logic period_end;  // last clock of the last slot of a period
  } spd_tick_t;
endpackage

// File: rtl/spd_timebase.sv
module spd_timebase #(
  parameter int PRE_W  = 2,
  parameter int SLOT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [PRE_W-1:0]      pre_q,
  output logic [SLOT_W-1:0]     slot_q,
  output spd_pkg::spd_tick_t    tick
);
  localparam logic [PRE_W-1:0]  PRE_LAST  = '1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = '1;
  localparam logic [PRE_W-1:0]  PRE_INC   = PRE_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_INC  = SLOT_W'(1);

  logic [PRE_W-1:0]  pre_d;
  logic [SLOT_W-1:0] slot_d;
  logic              slot_en;

  always_comb begin
    tick.slot_tick  = (pre_q == PRE_LAST);
    tick.period_end = tick.slot_tick && (slot_q == SLOT_LAST);
    slot_en         = tick.slot_tick;
    pre_d           = pre_q + PRE_INC;
    slot_d          = slot_q + SLOT_INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else begin
      pre_q <= pre_d;
      if (slot_en) slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/spd_channel.sv
module spd_channel #(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  spd_pkg::spd_tick_t tick,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic               out_en,
  input  logic               invert,
  output logic               pin_drive,
  output logic               pin_oe
);
  logic [DW-1:0] stage_q, level_q, acc_q;
  logic [DW-1:0] acc_d;
  logic [DW:0]   sum;
  logic          slot_hi;
  logic          drive_d;
  logic          acc_en, level_en;

  // Phase accumulator: carry-out of acc + level marks a high slot.
  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, level_q};
    slot_hi  = sum[DW];
    acc_en   = tick.slot_tick;
    acc_d    = tick.period_end ? '0 : sum[DW-1:0];
    level_en = tick.period_end;
    drive_d  = out_en & (slot_hi ^ invert);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      level_q   <= '0;
      acc_q     <= '0;
      pin_drive <= 1'b0;
      pin_oe    <= 1'b0;
    end else begin
      if (wr_en)    stage_q <= wr_data;
      if (level_en) level_q <= stage_q;
      if (acc_en)   acc_q   <= acc_d;
      pin_drive <= drive_d;
      pin_oe    <= out_en;
    end
  end
endmodule

// File: rtl/spread_pulse_dac.sv
module spread_pulse_dac #(
  parameter int NCH   = 2,
  parameter int DW    = 8,
  parameter int PRE_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCH-1:0]  out_en,
  input  logic [NCH-1:0]  invert,
  output logic [NCH-1:0]  pin_drive,
  output logic [NCH-1:0]  pin_oe
);
  logic [PRE_W-1:0]   pre_cnt;
  logic [DW-1:0]      slot_cnt;
  spd_pkg::spd_tick_t tick;

  spd_timebase #(.PRE_W(PRE_W), .SLOT_W(DW)) tb_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .pre_q  (pre_cnt),
    .slot_q (slot_cnt),
    .tick   (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    spd_channel #(.DW(DW)) ch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_en     (wr_en[c]),
      .wr_data   (wr_data),
      .out_en    (out_en[c]),
      .invert    (invert[c]),
      .pin_drive (pin_drive[c]),
      .pin_oe    (pin_oe[c])
    );
  end

  logic unused_slot;
  assign unused_slot = ^slot_cnt;
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int NCH   = 2,
  parameter int PRE_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   out_en,
  input logic [NCH-1:0]   invert,
  input logic [NCH-1:0]   pin_drive,
  input logic [NCH-1:0]   pin_oe,
  input logic [PRE_W-1:0] pre_cnt
);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [NCH-1:0] oe_q, oe_qq, inv_q, inv_qq, pd_q;
  logic [1:0]     warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0; oe_qq <= '0; inv_q <= '0; inv_qq <= '0; pd_q <= '0;
      warm <= '0;
    end else begin
      oe_q   <= out_en;
      oe_qq  <= oe_q;
      inv_q  <= invert;
      inv_qq <= inv_q;
      pd_q   <= pin_drive;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[c] |-> !pin_drive[c]);

    p_oe_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[c] == oe_q[c]);

    // R2: with steady controls the drive moves only one clock after a slot starts
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && pre_cnt != PRE_ONE &&
       oe_q[c] == oe_qq[c] && inv_q[c] == inv_qq[c])
      |-> pin_drive[c] == pd_q[c]);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r9: assert (pin_drive == '0 && pin_oe == '0)
        else $error("outputs active during reset");
    end
  end
endmodule

bind spread_pulse_dac spd_checker #(.NCH(NCH), .PRE_W(PRE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_en    (out_en),
  .invert    (invert),
  .pin_drive (pin_drive),
  .pin_oe    (pin_oe),
  .pre_cnt   (pre_cnt)
);

// File: tb/spread_pulse_dac_tb.sv
`timescale 1ns/1ps
module spread_pulse_dac_tb_top;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] wr_en, out_en, invert;
  logic [7:0]     wr_data;
  logic [NCH-1:0] pin_drive, pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R9";

  always #10 clk = ~clk;   // 50 MHz

  spread_pulse_dac #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .out_en(out_en), .invert(invert), .pin_drive(pin_drive), .pin_oe(pin_oe)
  );

  // Requirement-level model: slot s high iff floor((s+1)N/256) > floor(sN/256)
  function automatic bit slot_high(int s, int n);
    return ((s + 1) * n) / 256 > (s * n) / 256;
  endfunction

  function automatic int exp_total(bit oe, bit inv, int n);
    if (!oe) return 0;
    return inv ? 1024 - 4 * n : 4 * n;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  int         m_e;
  logic [7:0] m_stage [NCH];
  logic [7:0] m_level [NCH];
  logic [NCH-1:0] e_pin, e_oe, e_inv;
  int         e_slot, e_pre;
  int         e_lvl [NCH];
  bit         e_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_e <= 0; e_pin <= '0; e_oe <= '0; e_inv <= '0;
      e_slot <= 0; e_pre <= 0; e_valid <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        m_stage[c] <= '0; m_level[c] <= '0; e_lvl[c] <= 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        e_pin[c] <= out_en[c] & (slot_high((m_e / 4) % 256, int'(m_level[c])) ^ invert[c]);
        e_lvl[c] <= int'(m_level[c]);
        if ((m_e % 4) == 3 && ((m_e / 4) % 256) == 255) m_level[c] <= m_stage[c];
        if (wr_en[c]) m_stage[c] <= wr_data;
      end
      e_oe    <= out_en;
      e_inv   <= invert;
      e_slot  <= (m_e / 4) % 256;
      e_pre   <= m_e % 4;
      e_valid <= 1'b1;
      m_e     <= m_e + 1;
    end
  end

  int cnt [NCH];
  bit dirty [NCH];
  bit st_oe [NCH];
  bit st_inv [NCH];
  bit prev_hi [NCH];

  always @(negedge clk) begin
    if (rst_n && e_valid && !done) begin
      for (int c = 0; c < NCH; c++) begin
        check(pin_drive[c] == e_pin[c], cur_tag, pin_drive[c], e_pin[c]);
        check(pin_oe[c] == e_oe[c], "R5", pin_oe[c], e_oe[c]);
        if (e_slot == 0 && e_pre == 0) begin
          cnt[c] = int'(pin_drive[c]); dirty[c] = 0;
          st_oe[c] = e_oe[c]; st_inv[c] = e_inv[c]; prev_hi[c] = 0;
        end else begin
          cnt[c] += int'(pin_drive[c]);
          if (e_oe[c] != st_oe[c] || e_inv[c] != st_inv[c]) dirty[c] = 1;
        end
        if (e_pre == 3 && !dirty[c] && st_oe[c] && !st_inv[c]) begin
          if (e_lvl[c] <= 128 && e_slot != 0)
            check(!(pin_drive[c] && prev_hi[c]), "R3", 1, 0);
          prev_hi[c] = pin_drive[c];
        end
        if (e_pre == 3 && e_slot == 255 && !dirty[c]) begin
          if (e_lvl[c] == 0 || e_lvl[c] == 255)
            check(cnt[c] == exp_total(st_oe[c], st_inv[c], e_lvl[c]), "R4",
                  cnt[c], exp_total(st_oe[c], st_inv[c], e_lvl[c]));
          else
            check(cnt[c] == exp_total(st_oe[c], st_inv[c], e_lvl[c]),
                  st_inv[c] ? "R6" : "R1",
                  cnt[c], exp_total(st_oe[c], st_inv[c], e_lvl[c]));
        end
      end
    end
  end

  task automatic write_lvl(logic [NCH-1:0] mask, logic [7:0] val);
    @(negedge clk);
    wr_en = mask; wr_data = val;
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic wait_periods(int n);
    repeat (n * 1024) @(negedge clk);
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'h5eed);
    rst_n = 1'b0; wr_en = '0; wr_data = '0; out_en = '0; invert = '0;
    repeat (3) @(negedge clk);
    check(pin_drive == '0, "R9", pin_drive, 0);
    check(pin_oe == '0, "R9", pin_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pin_drive == '0, "R9", pin_drive, 0);

    cur_tag = "R4";
    out_en = '1;
    write_lvl(2'b01, 8'd0);
    write_lvl(2'b10, 8'd255);
    wait_periods(3);

    cur_tag = "R3";
    write_lvl(2'b01, 8'd1);
    write_lvl(2'b10, 8'd128);
    wait_periods(2);
    write_lvl(2'b01, 8'd3);
    write_lvl(2'b10, 8'd77);
    wait_periods(2);

    cur_tag = "R6";
    invert = 2'b01;
    wait_periods(2);
    invert = '0;

    cur_tag = "R7";
    repeat (500) @(negedge clk);
    write_lvl(2'b11, 8'd9);
    write_lvl(2'b11, 8'd200);
    wait_periods(2);

    cur_tag = "R8";
    write_lvl(2'b01, 8'd10);
    wait_periods(2);

    cur_tag = "R5";
    out_en = '0; invert = '1;
    wait_periods(1);
    out_en = '1; invert = '0;

    cur_tag = "R2";
    for (int i = 0; i < 16; i++) begin
      repeat ($urandom_range(1500, 1)) @(negedge clk);
      case ($urandom_range(3, 0))
        0, 1: write_lvl(NCH'($urandom_range(3, 1)), 8'($urandom_range(255, 0)));
        2:    out_en = NCH'($urandom_range(3, 0));
        default: invert = NCH'($urandom_range(3, 0));
      endcase
    end
    out_en = '1; invert = '0;
    wait_periods(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule